// File: doc/BRIEF.md
# GPIO Pad Controller with Routed Interrupts

This block controls a bank of general-purpose pads through a 32-bit register port. The pads sit in groups. Each group has address room for fifteen pads, and only the first `PADS_PER_GROUP` positions are populated. Every pad owns two configuration words. The first word holds the received level, the driven output value and a 4-bit selector that names one of sixteen shared interrupt lines. The second word holds the detection mode and an inversion field.

Pad inputs pass through a two-flop synchronizer. Each pad then detects falling edges, rising edges, both edges or a high level on its synchronized input, which may first be inverted. A detected event sets the status bit of the line that the pad's selector names. A 16-bit enable register gates the status bits, and the OR of the gated bits drives one combined interrupt output. Software clears a status bit by writing a one to it.

The register port has no back-pressure. A request is accepted in every cycle in which `req_valid` is high. A read returns its data in the following cycle, flagged by `rsp_valid`. Writes produce no response.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset the status register, the enable register, every pad's configuration, `pad_out`, `irq` and `rsp_valid` are all zero.
- R2: Status is at byte offset 0x0300 and enable is at 0x0380, with line n in bit n. Populated pad i of group g has its first word at 0x4400 + 1024*g + 8*i and its second word 4 bytes higher. Its pad index is g*PADS_PER_GROUP + i.
- R3: A read accepted at a clock edge raises `rsp_valid` for exactly the next cycle, with the data. A read returns 0 when it is misaligned, hits an unmapped offset, hits a slot at or beyond `PADS_PER_GROUP`, or hits a group at or beyond `NUM_GROUPS`.
- R4: First word layout. Bit 0 is the synchronized received level and ignores writes. Bit 1 is stored and drives the pad's bit of `pad_out`. Bits 31:28 are the line selector. All other bits read 0. `pad_out` changes only through writes.
- R5: Second word layout. Bits 2:0 are the detection mode and bits 7:4 are the inversion field. Both are stored as written, and all other bits read 0.
- R6: Mode 1 detects a 1-to-0 change of the detected signal, mode 2 a 0-to-1 change and mode 3 either change. A change on `pad_in` ahead of clock edge k sets the status bit by edge k+3.
- R7: Mode 4 sets the status bit on every clock while the detected signal is 1, so a clear does not last while that holds. Modes 0, 5, 6 and 7 never set status.
- R8: When bit 6 is set (inversion field value 0x4), the detected signal is the inverse of the synchronized input. Otherwise it is the synchronized input itself.
- R9: A pad event sets only the status bit whose index equals that pad's selector.
- R10: Writing status clears every bit written as 1 and leaves every bit written as 0 untouched. A hardware set and a clear of the same bit in one cycle leave the bit set.
- R11: `irq` is high exactly when some status bit is 1 and its enable bit is 1. Enable bits load from write data bits 15:0.
- R12: A write whose address has bits 1:0 nonzero changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NUM_GROUPS*PADS_PER_GROUP | Raw pad levels, asynchronous |
| pad_out | output | NUM_GROUPS*PADS_PER_GROUP | Driven pad values from bit 1 of each first word |
| req_valid | input | 1 | Register request, accepted every cycle it is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with two groups of five pads. This makes ten pads, an unpopulated slot range inside each group and a nonexistent third group, all within reach. It sweeps every pad through every detection mode, with and without inversion. Each pad is routed to a line computed from its index and mode, and the bench drives both input transitions. This covers routing to all sixteen lines, clear-versus-set resolution in level mode and enable gating. Directed accesses cover the decode holes, misaligned traffic, read-only bits and write-zero to status.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int NUM_LINES = 16;
  localparam int SEL_W     = $clog2(NUM_LINES);
  localparam int MAX_SLOTS = 15;

  localparam logic [ADDR_W-1:0] STAT_OFF = 16'h0300;
  localparam logic [ADDR_W-1:0] EN_OFF   = 16'h0380;
  localparam logic [ADDR_W-1:0] PAD_BASE = 16'h4400;
  // word-address strides: 1024 bytes per group, 8 bytes per slot
  localparam int GRP_SHIFT = 8;

  typedef enum logic [2:0] {
    DET_NONE  = 3'd0,
    DET_FALL  = 3'd1,
    DET_RISE  = 3'd2,
    DET_BOTH  = 3'd3,
    DET_LEVEL = 3'd4
  } det_mode_e;

  function automatic logic det_hit(input logic [2:0] mode, input logic prev, input logic cur);
    logic hit;
    case (mode)
      DET_FALL:  hit = prev & ~cur;
      DET_RISE:  hit = ~prev & cur;
      DET_BOTH:  hit = prev ^ cur;
      DET_LEVEL: hit = cur;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpio_pad_unit.sv
module gpio_pad_unit
  import gpio_pad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_sync,
  input  logic                 wr_cfg0,
  input  logic                 wr_cfg1,
  input  logic [SEL_W-1:0]     w_sel,
  input  logic                 w_tx,
  input  logic [2:0]           w_mode,
  input  logic [3:0]           w_inv,
  output logic [DATA_W-1:0]    cfg0_rd,
  output logic [DATA_W-1:0]    cfg1_rd,
  output logic                 tx,
  output logic [NUM_LINES-1:0] evt_lines
);
  logic [SEL_W-1:0] sel_q;
  logic             tx_q;
  logic [2:0]       mode_q;
  logic [3:0]       inv_q;
  logic             prev_q;
  logic             det_sig;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      tx_q  <= 1'b0;
    end else if (wr_cfg0) begin
      sel_q <= w_sel;
      tx_q  <= w_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      inv_q  <= '0;
    end else if (wr_cfg1) begin
      mode_q <= w_mode;
      inv_q  <= w_inv;
    end
  end

  // inversion acts on bit 6 of the second word (bit 2 of the field)
  assign det_sig = rx_sync ^ inv_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= det_sig;
  end

  assign hit       = det_hit(mode_q, prev_q, det_sig);
  assign evt_lines = hit ? (NUM_LINES'(1) << sel_q) : '0;
  assign tx        = tx_q;
  assign cfg0_rd   = {sel_q, {(DATA_W-SEL_W-2){1'b0}}, tx_q, rx_sync};
  assign cfg1_rd   = {{(DATA_W-8){1'b0}}, inv_q, 1'b0, mode_q};
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_vec,
  input  logic [LINES-1:0] clr_vec,
  input  logic             en_we,
  input  logic [LINES-1:0] en_wdata,
  output logic [LINES-1:0] status,
  output logic [LINES-1:0] enable,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_we) enable <= en_wdata;
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_GROUPS     = 2,
  parameter int PADS_PER_GROUP = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GROUPS*PADS_PER_GROUP-1:0] pad_in,
  output logic [NUM_GROUPS*PADS_PER_GROUP-1:0] pad_out,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [15:0]                          req_addr,
  input  logic [31:0]                          req_wdata,
  output logic                                 rsp_valid,
  output logic [31:0]                          rsp_rdata,
  output logic                                 irq
);
  localparam int NUM_PADS = NUM_GROUPS * PADS_PER_GROUP;
  localparam int WORD_W   = ADDR_W - 2;

  logic [NUM_PADS-1:0]  rx_sync;
  logic [NUM_PADS-1:0]  hit;
  logic [DATA_W-1:0]    cfg0_rd [NUM_PADS];
  logic [DATA_W-1:0]    cfg1_rd [NUM_PADS];
  logic [NUM_LINES-1:0] evt_lines [NUM_PADS];
  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] enable;
  logic [NUM_LINES-1:0] clr_vec;
  logic                 aligned;
  logic                 in_pad;
  logic [WORD_W-1:0]    word_off;
  logic [WORD_W-1:0]    grp;
  logic [6:0]           slot;
  logic                 second_word;
  logic                 do_wr;
  logic                 do_rd;
  logic [DATA_W-1:0]    rd_mux;
  logic                 unused_wdata;

  assign unused_wdata = ^req_wdata[27:16];

  assign aligned     = (req_addr[1:0] == 2'b00);
  assign in_pad      = (req_addr >= PAD_BASE);
  assign word_off    = req_addr[ADDR_W-1:2] - PAD_BASE[ADDR_W-1:2];
  assign grp         = word_off >> GRP_SHIFT;
  assign slot        = word_off[7:1];
  assign second_word = word_off[0];
  assign do_wr       = req_valid && req_write && aligned;
  assign do_rd       = req_valid && !req_write;

  gpio_pad_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (rx_sync)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int GRP_IDX  = p / PADS_PER_GROUP;
    localparam int SLOT_IDX = p % PADS_PER_GROUP;

    assign hit[p] = aligned && in_pad && (grp == WORD_W'(GRP_IDX)) && (slot == 7'(SLOT_IDX));

    gpio_pad_unit u_pad (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_sync   (rx_sync[p]),
      .wr_cfg0   (do_wr && hit[p] && !second_word),
      .wr_cfg1   (do_wr && hit[p] && second_word),
      .w_sel     (req_wdata[31:28]),
      .w_tx      (req_wdata[1]),
      .w_mode    (req_wdata[2:0]),
      .w_inv     (req_wdata[7:4]),
      .cfg0_rd   (cfg0_rd[p]),
      .cfg1_rd   (cfg1_rd[p]),
      .tx        (pad_out[p]),
      .evt_lines (evt_lines[p])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < NUM_PADS; p++) set_vec = set_vec | evt_lines[p];
  end

  assign clr_vec = (do_wr && req_addr == STAT_OFF) ? req_wdata[NUM_LINES-1:0] : '0;

  gpio_irq_bank #(.LINES(NUM_LINES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .en_we    (do_wr && req_addr == EN_OFF),
    .en_wdata (req_wdata[NUM_LINES-1:0]),
    .status   (status),
    .enable   (enable),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (req_addr == STAT_OFF) rd_mux = {{(DATA_W-NUM_LINES){1'b0}}, status};
      if (req_addr == EN_OFF)   rd_mux = {{(DATA_W-NUM_LINES){1'b0}}, enable};
      for (int p = 0; p < NUM_PADS; p++) begin
        if (hit[p]) rd_mux = second_word ? cfg1_rd[p] : cfg0_rd[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NUM_PADS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [15:0]         req_addr,
  input logic [15:0]         wdata_lo,
  input logic                rsp_valid,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [15:0]         status,
  input logic [15:0]         enable,
  input logic [15:0]         set_vec,
  input logic                irq
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R3
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R3
  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'h0)); // R3
  AST_PAD_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(pad_out)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 16'h0300) |=>
      ((status & $past(wdata_lo) & ~$past(set_vec)) == 16'h0)); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'h0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R10
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 16'h0380) |=> (enable == $past(wdata_lo))); // R11
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable != 16'h0 && status != 16'h0)); // R11
  AST_MISALIGNED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[1:0] != 2'b00) |=> ($stable(enable) && $stable(pad_out))); // R12
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .wdata_lo  (req_wdata[15:0]),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pad_out   (pad_out),
  .status    (status),
  .enable    (enable),
  .set_vec   (set_vec),
  .irq       (irq)
);

// File: tb/gpio_pad_ctrl_test.sv
module gpio_pad_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG  = 2;
  localparam int PPG = 5;
  localparam int NP  = NG * PPG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] exp_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_ctrl #(.NUM_GROUPS(NG), .PADS_PER_GROUP(PPG)) uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    check("R3 rsp_valid", {31'h0, rsp_valid}, 32'h1);
  endtask

  function automatic logic [15:0] pad_addr(input int p);
    return 16'(32'h4400 + 1024 * (p / PPG) + 8 * (p % PPG));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    wait_cyc(3);
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(2);
    bus_read(16'h0300, rd); check("R1 status", rd, 32'h0);
    bus_read(16'h0380, rd); check("R1 enable", rd, 32'h0);
    bus_read(pad_addr(7) + 16'h4, rd); check("R1 cfg1", rd, 32'h0);

    // R4 first word layout, rx read-only, tx drives pad
    pad_in[3] = 1'b1;
    wait_cyc(4);
    bus_read(pad_addr(3), rd); check("R4 rx level", rd, 32'h1);
    bus_write(pad_addr(3), 32'hAFFF_FFFE);
    exp_out[3] = 1'b1;
    bus_read(pad_addr(3), rd); check("R4 cfg0 readback", rd, 32'hA000_0003);
    check("R4 pad_out", 32'(pad_out), 32'(exp_out));
    // R5 second word layout
    bus_write(pad_addr(3) + 16'h4, 32'hFFFF_FFFF);
    bus_read(pad_addr(3) + 16'h4, rd); check("R5 cfg1 readback", rd, 32'h0000_00F7);
    bus_write(pad_addr(3) + 16'h4, 32'h0);
    bus_write(pad_addr(3), 32'h0);
    exp_out[3] = 1'b0;
    pad_in[3] = 1'b0;
    wait_cyc(4);

    // R3 decode holes
    bus_write(16'h4400 + 16'd40, 32'hFFFF_FFFF);
    bus_read(16'h4400 + 16'd40, rd); check("R3 unpopulated slot", rd, 32'h0);
    bus_read(16'h4400 + 16'd1024 + 16'd112, rd); check("R3 slot 14", rd, 32'h0);
    bus_read(16'h4400 + 16'd2048, rd); check("R3 missing group", rd, 32'h0);
    bus_read(16'h0100, rd); check("R3 unmapped", rd, 32'h0);
    bus_read(16'h0304, rd); check("R3 unmapped near status", rd, 32'h0);
    bus_write(16'h0380, 32'h0000_1234);
    bus_read(16'h0381, rd); check("R3 misaligned read", rd, 32'h0);
    // R12 misaligned write ignored
    bus_write(16'h0382, 32'h0000_FFFF);
    bus_write(pad_addr(0) + 16'h1, 32'h0000_0002);
    bus_read(16'h0380, rd); check("R12 enable kept", rd, 32'h0000_1234);
    check("R12 pad_out kept", 32'(pad_out), 32'(exp_out));
    bus_write(16'h0380, 32'h0);

    // R10 write-zero and R11 gating, pad 6 rising on line 5
    bus_write(pad_addr(6), 32'h5000_0000);
    bus_write(pad_addr(6) + 16'h4, 32'h2);
    pad_in[6] = 1'b1;
    wait_cyc(5);
    bus_read(16'h0300, rd); check("R6 rise pad6", rd, 32'h0000_0020);
    check("R11 irq gated off", {31'h0, irq}, 32'h0);
    bus_write(16'h0300, 32'h0);
    bus_read(16'h0300, rd); check("R10 write zero no effect", rd, 32'h0000_0020);
    bus_write(16'h0380, 32'h0000_0020);
    wait_cyc(1);
    check("R11 irq on", {31'h0, irq}, 32'h1);
    bus_write(16'h0300, 32'h0000_0020);
    bus_read(16'h0300, rd); check("R10 w1c", rd, 32'h0);
    check("R11 irq off after clear", {31'h0, irq}, 32'h0);
    bus_write(pad_addr(6) + 16'h4, 32'h0);
    bus_write(pad_addr(6), 32'h0);
    pad_in[6] = 1'b0;
    wait_cyc(4);

    // Sweep: every pad, every mode, inversion off/on
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 5; m++) begin
        for (int inv = 0; inv < 2; inv++) begin
          int line;
          logic tx;
          logic [31:0] bit_l;
          logic exp_b, exp_b2, exp_c, exp_c2, exp_a;
          line  = (p * 3 + m + inv) % 16;
          tx    = 1'((p + m) % 2);
          bit_l = 32'h1 << line;
          exp_a  = (m == 4) && (inv == 1);
          exp_b  = (m == 3) || (m == 4) || (m == 2 && inv == 0) || (m == 1 && inv == 1);
          exp_b2 = (m == 4) && (inv == 0);
          exp_c  = (m == 3) || (m == 4) || (m == 1 && inv == 0) || (m == 2 && inv == 1);
          exp_c2 = (m == 4) && (inv == 1);

          bus_write(pad_addr(p) + 16'h4, 32'(inv) << 6);
          wait_cyc(4);
          bus_write(16'h0300, 32'h0000_FFFF);
          bus_write(16'h0380, bit_l);
          bus_write(pad_addr(p), (32'(line) << 28) | (32'(tx) << 1));
          exp_out[p] = tx;
          bus_write(pad_addr(p) + 16'h4, (32'(inv) << 6) | 32'(m));
          wait_cyc(4);
          bus_read(16'h0300, rd); check("R7 R8 idle level", rd, exp_a ? bit_l : 32'h0);
          check("R11 irq idle", {31'h0, irq}, {31'h0, exp_a});
          check("R4 pad_out sweep", 32'(pad_out), 32'(exp_out));
          bus_write(16'h0300, 32'h0000_FFFF);

          pad_in[p] = 1'b1;
          wait_cyc(5);
          bus_read(16'h0300, rd); check("R6 R9 after rise", rd, exp_b ? bit_l : 32'h0);
          check("R11 irq after rise", {31'h0, irq}, {31'h0, exp_b});
          bus_write(16'h0300, 32'h0000_FFFF);
          wait_cyc(1);
          bus_read(16'h0300, rd); check("R7 R10 high held", rd, exp_b2 ? bit_l : 32'h0);

          pad_in[p] = 1'b0;
          wait_cyc(5);
          bus_read(16'h0300, rd); check("R6 R8 after fall", rd, exp_c ? bit_l : 32'h0);
          bus_write(16'h0300, 32'h0000_FFFF);
          wait_cyc(1);
          bus_read(16'h0300, rd); check("R7 R8 low held", rd, exp_c2 ? bit_l : 32'h0);

          bus_write(pad_addr(p) + 16'h4, 32'h0);
          bus_read(pad_addr(p), rd);
          check("R2 R4 cfg0 sweep", rd, (32'(line) << 28) | (32'(tx) << 1));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule